// File: doc/BRIEF.md
# Break and Sync Baud-Rate Detector

This block watches an asynchronous serial receive line for a header made of three parts: a long low break, a high delimiter, and a sync character carrying the value 0x55. From the sync character it measures the bit period in reference-clock cycles. It publishes that period as a prescaler value together with a one-cycle strobe. A receiver placed next to it can then load the value as its new baud divider. Data reception after the sync character is not part of this block.

Break and delimiter lengths are judged against the prescaler value the block currently holds. After reset this is a parameter; after a measurement it is the last measured value. A break that lasts too long, and a sync character that outlasts the measuring counter, each raise their own sticky error flag. A break that is recognised raises a sticky detect flag. All three flags drop only when the clear input is asserted. While the enable input is low, the block ignores the line entirely.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `prescale_o` equals the parameter `INIT_PRESCALE`, and `prescale_valid_o`, `brk_det_o`, `brk_timeout_o` and `sync_timeout_o` are all low.
- R2: A low run on the line of at least 11·P cycles, where P is the current prescaler value, sets `brk_det_o`. A shorter low run sets nothing and starts no measurement.
- R3: A low run longer than 22·P cycles sets `brk_timeout_o` (with `brk_det_o` already high) and abandons the header. Any sync character that follows is ignored.
- R4: The delimiter code `delim_sel_i` = d (0 to 3) requires the line to stay high for at least (d+1)·P cycles between the end of the break and the sync start bit. If the high time is shorter, no measurement is made.
- R5: The prescaler is the cycle count from the falling edge of the sync start bit to the fifth falling edge (the one that opens data bit 7, data sent LSB first), divided by 8 and truncated. The new value appears on `prescale_o` in the same cycle as a one-cycle `prescale_valid_o` pulse.
- R6: A sync character whose second, third or fourth falling-edge interval differs from the first interval by more than one quarter of the first is rejected. No strobe is given, and `prescale_o` keeps its value. For example, 0x35 is rejected.
- R7: If the sync measurement counter (PW+3 bits) reaches its all-ones value before the fifth falling edge, `sync_timeout_o` is set and no strobe is given.
- R8: Break recognition always uses the most recently measured prescaler. For example, a low run that would be a break at P=16 is not a break at P=40.
- R9: While `enable_i` is low, no flag is set and no strobe is given. A header in progress when `enable_i` drops is abandoned.
- R10: `brk_det_o`, `brk_timeout_o` and `sync_timeout_o` stay high until `clear_i` is asserted, which drops them in the next cycle.
- R11: `prescale_o` changes only in a cycle where `prescale_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Detection enable |
| rx_i | input | 1 | Asynchronous serial receive line (idle high) |
| delim_sel_i | input | 2 | Minimum delimiter length code, (code+1) bit times |
| clear_i | input | 1 | Clears the three sticky flags |
| prescale_o | output | PW | Current prescaler (cycles per bit) |
| prescale_valid_o | output | 1 | One-cycle strobe when a new prescaler is loaded |
| brk_det_o | output | 1 | Sticky break-recognised flag |
| brk_timeout_o | output | 1 | Sticky break-too-long error |
| sync_timeout_o | output | 1 | Sticky sync-too-long error |

## Verification
The bench drives whole headers at several bit periods and checks that each is measured exactly. It also checks that a break which suits the old rate but is too short for the newly measured one is refused; a design that kept the reset threshold would accept it. It sends a delimiter one bit time short for code 3 and a distorted 0x35 sync character; a design without these checks would publish a wrong prescaler. Finally, it holds the break past 22 bit times and the sync start bit past the counter range, and confirms that the matching error flag rises and stays up until it is cleared.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BREAK = 3'd1,
    ST_HOLD  = 3'd2,
    ST_DELIM = 3'd3,
    ST_SYNC  = 3'd4
  } abd_state_e;

endpackage

// File: rtl/abd_rx_sync.sv
module abd_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      assign stg_d = rx_i;
    end else begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], rx_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign line_o = stg_q[STAGES-1];
  assign fall_o = prev_q & ~stg_q[STAGES-1];
  assign rise_o = ~prev_q & stg_q[STAGES-1];

endmodule

// File: rtl/abd_limits.sv
module abd_limits #(
  parameter int PW = 16,
  localparam int CW = PW + 5
) (
  input  logic [PW-1:0] prescale_i,
  input  logic [1:0]    delim_sel_i,
  output logic [CW-1:0] brk_min_o,
  output logic [CW-1:0] brk_max_o,
  output logic [CW-1:0] delim_min_o
);

  logic [CW-1:0] p_ext;

  assign p_ext     = {{(CW-PW){1'b0}}, prescale_i};
  // 11 bit times as 8 + 2 + 1, 22 bit times as twice that
  assign brk_min_o = (p_ext << 3) + (p_ext << 1) + p_ext;
  assign brk_max_o = brk_min_o << 1;

  always_comb begin
    unique case (delim_sel_i)
      2'd0:    delim_min_o = p_ext;
      2'd1:    delim_min_o = p_ext << 1;
      2'd2:    delim_min_o = (p_ext << 1) + p_ext;
      default: delim_min_o = p_ext << 2;
    endcase
  end

endmodule

// File: rtl/abd_sync_timer.sv
module abd_sync_timer #(
  parameter int PW = 16,
  localparam int MW = PW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          fall_i,
  output logic          done_o,
  output logic          bad_o,
  output logic          ovf_o,
  output logic [MW-1:0] meas_o
);

  logic [MW-1:0] cnt_q, cnt_d;
  logic [MW-1:0] mark_q, mark_d;
  logic [MW-1:0] iv1_q, iv1_d;
  logic [1:0]    idx_q, idx_d;
  logic [MW-1:0] now, iv, dev, tol;
  logic          at_max;
  logic          upd_en;

  assign at_max = &cnt_q;
  assign now    = cnt_q + 1'b1;
  assign iv     = now - mark_q;
  assign dev    = (iv > iv1_q) ? (iv - iv1_q) : (iv1_q - iv);
  assign tol    = iv1_q >> 2;
  assign meas_o = now;
  assign ovf_o  = run_i & at_max;
  assign upd_en = start_i | run_i;

  always_comb begin
    cnt_d  = cnt_q;
    mark_d = mark_q;
    iv1_d  = iv1_q;
    idx_d  = idx_q;
    done_o = 1'b0;
    bad_o  = 1'b0;
    if (start_i) begin
      cnt_d  = '0;
      mark_d = '0;
      iv1_d  = '0;
      idx_d  = '0;
    end else if (run_i && !at_max) begin
      cnt_d = now;
      if (fall_i) begin
        mark_d = now;
        idx_d  = idx_q + 2'd1;
        if (idx_q == 2'd0) begin
          iv1_d = now;
        end else if (dev > tol) begin
          bad_o = 1'b1;
        end else if (idx_q == 2'd3) begin
          done_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mark_q <= '0;
      iv1_q  <= '0;
      idx_q  <= '0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      mark_q <= mark_d;
      iv1_q  <= iv1_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import abd_pkg::*;
#(
  parameter int PW            = 16,
  parameter int INIT_PRESCALE = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          rx_i,
  input  logic [1:0]    delim_sel_i,
  input  logic          clear_i,
  output logic [PW-1:0] prescale_o,
  output logic          prescale_valid_o,
  output logic          brk_det_o,
  output logic          brk_timeout_o,
  output logic          sync_timeout_o
);

  localparam int CW = PW + 5;
  localparam int MW = PW + 3;

  abd_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_sat;
  logic [PW-1:0] prescale_q, prescale_d;
  logic          valid_q;
  logic          det_q, det_d;
  logic          bto_q, bto_d;
  logic          sto_q, sto_d;

  logic          line, fall, rise;
  logic [CW-1:0] brk_min, brk_max, delim_min;
  logic          tm_start, tm_run, tm_done, tm_bad, tm_ovf;
  logic [MW-1:0] tm_meas;
  logic          set_det, set_bto, set_sto, load;

  abd_rx_sync #(.STAGES(SYNC_STAGES)) rx_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall),
    .rise_o (rise)
  );

  abd_limits #(.PW(PW)) limits_i (
    .prescale_i  (prescale_q),
    .delim_sel_i (delim_sel_i),
    .brk_min_o   (brk_min),
    .brk_max_o   (brk_max),
    .delim_min_o (delim_min)
  );

  assign tm_run = enable_i && (state_q == ST_SYNC);

  abd_sync_timer #(.PW(PW)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tm_start),
    .run_i   (tm_run),
    .fall_i  (fall),
    .done_o  (tm_done),
    .bad_o   (tm_bad),
    .ovf_o   (tm_ovf),
    .meas_o  (tm_meas)
  );

  assign cnt_sat = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  // sequencing
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tm_start = 1'b0;
    set_det  = 1'b0;
    set_bto  = 1'b0;
    set_sto  = 1'b0;
    load     = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line) begin
            state_d = ST_BREAK;
            cnt_d   = {{(CW-1){1'b0}}, 1'b1};
          end
        end
        ST_BREAK: begin
          if (rise) begin
            if (cnt_q >= brk_min) begin
              state_d = ST_DELIM;
              cnt_d   = {{(CW-1){1'b0}}, 1'b1};
            end else begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_sat;
            if (cnt_sat >= brk_min) set_det = 1'b1;
            if (cnt_sat > brk_max) begin
              set_bto = 1'b1;
              state_d = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (line) state_d = ST_IDLE;
        end
        ST_DELIM: begin
          if (fall) begin
            if (cnt_q >= delim_min) begin
              state_d  = ST_SYNC;
              tm_start = 1'b1;
            end else begin
              state_d = ST_BREAK;
              cnt_d   = {{(CW-1){1'b0}}, 1'b1};
            end
          end else begin
            cnt_d = cnt_sat;
          end
        end
        ST_SYNC: begin
          if (tm_ovf) begin
            set_sto = 1'b1;
            state_d = ST_HOLD;
          end else if (tm_bad) begin
            state_d = ST_IDLE;
          end else if (tm_done) begin
            load    = |tm_meas[MW-1:3];
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign prescale_d = load ? tm_meas[MW-1:3] : prescale_q;
  assign det_d      = set_det | (det_q & ~clear_i);
  assign bto_d      = set_bto | (bto_q & ~clear_i);
  assign sto_d      = set_sto | (sto_q & ~clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      prescale_q <= PW'(INIT_PRESCALE);
      valid_q    <= 1'b0;
      det_q      <= 1'b0;
      bto_q      <= 1'b0;
      sto_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= load;
      det_q   <= det_d;
      bto_q   <= bto_d;
      sto_q   <= sto_d;
      if (load) prescale_q <= prescale_d;
    end
  end

  assign prescale_o       = prescale_q;
  assign prescale_valid_o = valid_q;
  assign brk_det_o        = det_q;
  assign brk_timeout_o    = bto_q;
  assign sync_timeout_o   = sto_q;

endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int PW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          clear_i,
  input logic [PW-1:0] prescale_o,
  input logic          prescale_valid_o,
  input logic          brk_det_o,
  input logic          brk_timeout_o,
  input logic          sync_timeout_o
);

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prescale_valid_o |=> !prescale_valid_o);

  // R5
  prescale_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prescale_valid_o |-> (prescale_o != '0));

  // R11
  prescale_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prescale_valid_o |-> $stable(prescale_o));

  // R9
  off_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !prescale_valid_o);

  // R9
  off_no_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !brk_det_o) |=> !brk_det_o);

  // R10
  det_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_det_o && !clear_i) |=> brk_det_o);

  // R10
  bto_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_timeout_o && !clear_i) |=> brk_timeout_o);

  // R10
  sto_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_timeout_o && !clear_i) |=> sync_timeout_o);

  // R3
  bto_after_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_timeout_o) |-> brk_det_o);

  // R7
  sto_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_timeout_o) |-> !prescale_valid_o);

endmodule

bind autobaud_detect abd_checker #(.PW(PW)) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .clear_i          (clear_i),
  .prescale_o       (prescale_o),
  .prescale_valid_o (prescale_valid_o),
  .brk_det_o        (brk_det_o),
  .brk_timeout_o    (brk_timeout_o),
  .sync_timeout_o   (sync_timeout_o)
);

// File: tb/autobaud_detect_tb_top.sv
module autobaud_detect_tb_top;

  localparam int PW   = 10;
  localparam int INIT = 16;

  typedef enum int {EV_DET = 0, EV_BTO = 1, EV_STO = 2, EV_VAL = 3} ev_e;
  typedef struct {
    ev_e   kind;
    int    val;
    string req;
  } ev_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0;
  logic          rx_i = 1'b1;
  logic [1:0]    delim_sel_i = 2'd0;
  logic          clear_i = 1'b0;
  logic [PW-1:0] prescale_o;
  logic          prescale_valid_o;
  logic          brk_det_o;
  logic          brk_timeout_o;
  logic          sync_timeout_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  mon_on   = 1'b0;
  bit  finished = 1'b0;
  bit  det_prev = 1'b0, bto_prev = 1'b0, sto_prev = 1'b0;
  ev_t exp_q[$];

  always #10 clk_i = ~clk_i;

  autobaud_detect #(.PW(PW), .INIT_PRESCALE(INIT), .SYNC_STAGES(2)) dut_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .enable_i         (enable_i),
    .rx_i             (rx_i),
    .delim_sel_i      (delim_sel_i),
    .clear_i          (clear_i),
    .prescale_o       (prescale_o),
    .prescale_valid_o (prescale_valid_o),
    .brk_det_o        (brk_det_o),
    .brk_timeout_o    (brk_timeout_o),
    .sync_timeout_o   (sync_timeout_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_ev(input ev_e k, input int v, input string req);
    ev_t e;
    e.kind = k;
    e.val  = v;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // monitor side of the scoreboard
  task automatic observe(input ev_e k, input int v);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected event kind", int'(k), -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
      if (e.kind == EV_VAL && k == EV_VAL)
        check(v == e.val, e.req, "measured prescaler", v, e.val);
    end
  endtask

  always @(negedge clk_i) begin
    if (mon_on) begin
      if (brk_det_o && !det_prev)     observe(EV_DET, 0);
      if (brk_timeout_o && !bto_prev) observe(EV_BTO, 0);
      if (sync_timeout_o && !sto_prev) observe(EV_STO, 0);
      if (prescale_valid_o)           observe(EV_VAL, int'(prescale_o));
    end
    det_prev = brk_det_o;
    bto_prev = brk_timeout_o;
    sto_prev = sync_timeout_o;
  end

  // all driving tasks start and end at 1 ns after a rising edge
  task automatic hold_line(input logic v, input int n);
    rx_i = v;
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int bp);
    hold_line(1'b0, bp);
    for (int i = 0; i < 8; i++) hold_line(b[i], bp);
    hold_line(1'b1, bp);
  endtask

  task automatic send_header(input int brk, input int dlm, input logic [7:0] b, input int bp);
    hold_line(1'b0, brk);
    hold_line(1'b1, dlm);
    send_byte(b, bp);
    hold_line(1'b1, 3 * bp + 20);
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1;
    @(posedge clk_i);
    #1;
    clear_i = 1'b0;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk_i);
    #1;
    // R1: reset state
    check(int'(prescale_o) == INIT, "R1", "prescaler at reset", int'(prescale_o), INIT);
    check(prescale_valid_o == 1'b0, "R1", "strobe at reset", int'(prescale_valid_o), 0);
    check(brk_det_o == 1'b0, "R1", "break flag at reset", int'(brk_det_o), 0);
    check(brk_timeout_o == 1'b0, "R1", "break error at reset", int'(brk_timeout_o), 0);
    check(sync_timeout_o == 1'b0, "R1", "sync error at reset", int'(sync_timeout_o), 0);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    mon_on = 1'b1;
    hold_line(1'b1, 10);

    // R2 R5: matching rate
    expect_ev(EV_DET, 0, "R2");
    expect_ev(EV_VAL, 16, "R5");
    send_header(12 * 16, 16, 8'h55, 16);
    pulse_clear();

    // R5: slower sync rate
    expect_ev(EV_DET, 0, "R2");
    expect_ev(EV_VAL, 40, "R5");
    send_header(12 * 16, 16, 8'h55, 40);
    pulse_clear();

    // R8: old-rate break is too short now
    hold_line(1'b0, 12 * 16);
    hold_line(1'b1, 200);
    check(brk_det_o == 1'b0, "R8", "short break against new rate", int'(brk_det_o), 0);
    check(int'(prescale_o) == 40, "R8", "prescaler kept", int'(prescale_o), 40);

    // R5: faster rate
    expect_ev(EV_DET, 0, "R2");
    expect_ev(EV_VAL, 25, "R5");
    send_header(12 * 40, 40, 8'h55, 25);
    pulse_clear();

    // R3: break too long, following sync ignored
    expect_ev(EV_DET, 0, "R3");
    expect_ev(EV_BTO, 0, "R3");
    hold_line(1'b0, 25 * 25);
    hold_line(1'b1, 100);
    send_byte(8'h55, 25);
    hold_line(1'b1, 100);
    check(brk_timeout_o == 1'b1, "R10", "break error held", int'(brk_timeout_o), 1);
    check(int'(prescale_o) == 25, "R3", "prescaler kept", int'(prescale_o), 25);
    pulse_clear();
    check(brk_timeout_o == 1'b0, "R10", "break error cleared", int'(brk_timeout_o), 0);

    // R4: code 3 needs four bit times of delimiter
    delim_sel_i = 2'd3;
    expect_ev(EV_DET, 0, "R4");
    send_header(12 * 25, 3 * 25, 8'h55, 33);
    check(int'(prescale_o) == 25, "R4", "short delimiter rejected", int'(prescale_o), 25);
    pulse_clear();
    expect_ev(EV_DET, 0, "R4");
    expect_ev(EV_VAL, 33, "R4");
    send_header(12 * 25, 4 * 25, 8'h55, 33);
    pulse_clear();
    delim_sel_i = 2'd0;

    // R6: distorted sync character
    expect_ev(EV_DET, 0, "R6");
    send_header(12 * 33, 33, 8'h35, 20);
    check(int'(prescale_o) == 33, "R6", "bad sync rejected", int'(prescale_o), 33);
    pulse_clear();

    // R9: disabled, then dropped mid-header
    enable_i = 1'b0;
    send_header(12 * 33, 33, 8'h55, 20);
    check(brk_det_o == 1'b0, "R9", "no break while disabled", int'(brk_det_o), 0);
    check(int'(prescale_o) == 33, "R9", "no update while disabled", int'(prescale_o), 33);
    enable_i = 1'b1;
    hold_line(1'b1, 20);
    expect_ev(EV_DET, 0, "R9");
    hold_line(1'b0, 12 * 33);
    hold_line(1'b1, 33);
    enable_i = 1'b0;
    send_byte(8'h55, 20);
    enable_i = 1'b1;
    hold_line(1'b1, 60);
    check(int'(prescale_o) == 33, "R9", "aborted header", int'(prescale_o), 33);
    pulse_clear();

    // R7: start bit outlasts the 13-bit counter
    expect_ev(EV_DET, 0, "R7");
    expect_ev(EV_STO, 0, "R7");
    hold_line(1'b0, 12 * 33);
    hold_line(1'b1, 33);
    hold_line(1'b0, 9000);
    hold_line(1'b1, 50);
    check(sync_timeout_o == 1'b1, "R10", "sync error held", int'(sync_timeout_o), 1);
    check(int'(prescale_o) == 33, "R7", "prescaler kept", int'(prescale_o), 33);
    pulse_clear();
    check(sync_timeout_o == 1'b0, "R10", "sync error cleared", int'(sync_timeout_o), 0);

    // R5: recovery after errors
    expect_ev(EV_DET, 0, "R2");
    expect_ev(EV_VAL, 20, "R5");
    send_header(12 * 33, 33, 8'h55, 20);
    pulse_clear();

    check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule